// File: doc/BRIEF.md
# Gray-Level Texture Code Unit

This block turns each 8-bit grayscale pixel into one small feature code that carries both the local texture and the brightness of that pixel. Each valid cycle it takes a complete 3x3 window of samples around a centre pixel. It compares the eight surrounding samples against the centre. When the ring of comparison bits has at most two transitions, the texture label is the number of neighbours that are not below the centre. Otherwise the label is a single catch-all value. The unit then adds a coarse luminance term taken from the centre's brightness bin. The bins are spaced ten codes apart, so one code in the range 0 to 39 identifies both the texture class and the brightness class.

A smoothing front stage can be switched in on any beat. When it is on, the centre sample is replaced by a weighted mean of itself and its four edge-adjacent samples before the comparison and the binning take place. The corner samples and the four edge samples are passed on unchanged. The unit is fully pipelined: it accepts one window per cycle, and each code leaves the unit exactly three cycles after its window arrived. It is meant to feed a histogram stage that sits downstream of a line-buffer stage.

Top module: `glbp_code_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `out_code` is 0.
- R2: `out_valid` in cycle n+3 equals `in_valid` in cycle n. Back-to-back beats and gaps between beats keep their pattern, and each code belongs to the window presented three cycles earlier.
- R3: Window tap k = 3*row + col, with row 0 at the top, occupies `win[8k+7:8k]`. The centre is tap 4. A neighbour's comparison bit is 1 when the neighbour is greater than or equal to the centre, so a neighbour equal to the centre gives a 1.
- R4: The ring order is taps 0,1,2,5,8,7,6,3, and this order is cyclic. When the ring has at most 2 bit changes, the texture label is the number of 1 bits (0 to 8).
- R5: The comparison between ring position 7 (tap 3) and ring position 0 (tap 0) counts as a transition. When the ring has more than 2 changes, the texture label is 9.
- R6: The luminance term is 0 for a centre below 64, 10 for a centre from 64 to 127, 20 for a centre from 128 to 191, and 30 for a centre of 192 or more.
- R7: `out_code` equals the luminance term plus the texture label, and it never exceeds 39.
- R8: When `smooth_en` is 1 on a beat, the centre used for that beat is (4*tap4 + tap1 + tap7 + tap3 + tap5) >> 3, computed without overflow on an 11-bit sum. When `smooth_en` is 0, the raw tap 4 is used. Neighbours are never altered.
- R9: In every cycle in which `out_valid` is 0, `out_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The window on `win` is a beat this cycle |
| smooth_en | input | 1 | Apply centre smoothing to this beat |
| win | input | 72 | Nine 8-bit taps, tap k at bits 8k+7:8k |
| out_valid | output | 1 | `out_code` carries a result this cycle |
| out_code | output | 6 | Luminance term plus texture label, 0 to 39 |

## Verification
Centre smoothing and luminance binning can both act on the same beat, and the smoothed value can move the centre into a different bin. The uniformity decision can also change on that beat, because the neighbours are compared against the smoothed centre and not the raw one. Directed beats place a raw centre and a smoothed centre on opposite sides of a bin threshold, and they turn a flat ring into an alternating one. A scoreboard then compares each code with a value computed in the bench from the requirements. Random beats mix both settings of `smooth_en` with neighbours chosen equal to the centre, and these beats come back to back and with gaps, so that the three-cycle alignment is judged at the same time.

// File: rtl/glbp_pkg.sv
package glbp_pkg;

    // Eight neighbours at radius one around the centre of a 3x3 window.
    localparam int unsigned RING_LEN     = 8;
    localparam int unsigned WIN_TAPS     = 9;
    localparam int unsigned CENTRE_TAP   = 4;
    // Texture labels run 0..RING_LEN plus one catch-all, so bins are RING_LEN+2 apart.
    localparam int unsigned LABEL_MIXED  = RING_LEN + 1;
    localparam int unsigned CODE_SPACING = RING_LEN + 2;
    localparam int unsigned MAX_TRANS    = 2;

    // Edge-adjacent taps used by the smoothing kernel.
    localparam int unsigned TAP_UP    = 1;
    localparam int unsigned TAP_LEFT  = 3;
    localparam int unsigned TAP_RIGHT = 5;
    localparam int unsigned TAP_DOWN  = 7;

    // Ring position -> window tap, walking clockwise from the top-left corner.
    function automatic int unsigned ring_tap(input int unsigned pos);
        case (pos)
            0:       ring_tap = 0;
            1:       ring_tap = 1;
            2:       ring_tap = 2;
            3:       ring_tap = 5;
            4:       ring_tap = 8;
            5:       ring_tap = 7;
            6:       ring_tap = 6;
            default: ring_tap = 3;
        endcase
    endfunction

endpackage

// File: rtl/glbp_smooth_stage.sv
module glbp_smooth_stage #(
    parameter int unsigned PIX_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic                                 smooth_en,
    input  logic [glbp_pkg::WIN_TAPS*PIX_W-1:0]  win,
    output logic                                 s1_valid,
    output logic [PIX_W-1:0]                     s1_centre,
    output logic [glbp_pkg::RING_LEN*PIX_W-1:0]  s1_ring
);
    import glbp_pkg::*;

    localparam int unsigned SUM_W  = PIX_W + 3;
    localparam int unsigned RING_W = RING_LEN * PIX_W;

    logic [PIX_W-1:0] raw_centre;
    logic [SUM_W-1:0] kernel_sum;
    logic [PIX_W-1:0] smoothed;
    logic [PIX_W-1:0] centre_sel;
    logic [RING_W-1:0] ring_gather;

    assign raw_centre = win[CENTRE_TAP*PIX_W +: PIX_W];

    always_comb begin
        kernel_sum = {1'b0, raw_centre, 2'b00}
                   + SUM_W'(win[TAP_UP*PIX_W    +: PIX_W])
                   + SUM_W'(win[TAP_DOWN*PIX_W  +: PIX_W])
                   + SUM_W'(win[TAP_LEFT*PIX_W  +: PIX_W])
                   + SUM_W'(win[TAP_RIGHT*PIX_W +: PIX_W]);
        smoothed   = kernel_sum[SUM_W-1:3];
        centre_sel = smooth_en ? smoothed : raw_centre;
    end

    for (genvar p = 0; p < RING_LEN; p++) begin : g_ring
        assign ring_gather[p*PIX_W +: PIX_W] = win[ring_tap(p)*PIX_W +: PIX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_centre <= '0;
            s1_ring   <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_centre <= in_valid ? centre_sel  : '0;
            s1_ring   <= in_valid ? ring_gather : '0;
        end
    end

endmodule

// File: rtl/glbp_sign_stage.sv
module glbp_sign_stage #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned LUMA_BINS = 4,
    parameter int unsigned CODE_W    = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 s1_valid,
    input  logic [PIX_W-1:0]                     s1_centre,
    input  logic [glbp_pkg::RING_LEN*PIX_W-1:0]  s1_ring,
    output logic                                 s2_valid,
    output logic [glbp_pkg::RING_LEN-1:0]        s2_signs,
    output logic [CODE_W-1:0]                    s2_offset
);
    import glbp_pkg::*;

    localparam int unsigned BIN_BITS = $clog2(LUMA_BINS);

    logic [RING_LEN-1:0] signs_d;
    logic [CODE_W-1:0]   offset_d;

    for (genvar p = 0; p < RING_LEN; p++) begin : g_cmp
        assign signs_d[p] = (s1_ring[p*PIX_W +: PIX_W] >= s1_centre);
    end

    if (BIN_BITS == 0) begin : g_single_bin
        assign offset_d = '0;
    end else begin : g_multi_bin
        logic [BIN_BITS-1:0] bin_idx;
        assign bin_idx  = s1_centre[PIX_W-1 -: BIN_BITS];
        assign offset_d = CODE_W'(bin_idx) * CODE_W'(CODE_SPACING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_signs  <= '0;
            s2_offset <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_signs  <= s1_valid ? signs_d  : '0;
            s2_offset <= s1_valid ? offset_d : '0;
        end
    end

endmodule

// File: rtl/glbp_label_stage.sv
module glbp_label_stage #(
    parameter int unsigned CODE_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s2_valid,
    input  logic [glbp_pkg::RING_LEN-1:0] s2_signs,
    input  logic [CODE_W-1:0]             s2_offset,
    output logic                          out_valid,
    output logic [CODE_W-1:0]             out_code
);
    import glbp_pkg::*;

    localparam int unsigned CNT_W = $clog2(RING_LEN + 2);

    logic [RING_LEN-1:0] edges;
    logic [CNT_W-1:0]    trans_cnt;
    logic [CNT_W-1:0]    ones_cnt;
    logic [CNT_W-1:0]    label;
    logic [CODE_W-1:0]   code_d;

    // Neighbouring ring positions, including last-to-first.
    for (genvar p = 0; p < RING_LEN; p++) begin : g_edge
        assign edges[p] = s2_signs[p] ^ s2_signs[(p + 1) % RING_LEN];
    end

    always_comb begin
        trans_cnt = '0;
        ones_cnt  = '0;
        for (int p = 0; p < RING_LEN; p++) begin
            trans_cnt = trans_cnt + CNT_W'(edges[p]);
            ones_cnt  = ones_cnt  + CNT_W'(s2_signs[p]);
        end
        label  = (trans_cnt <= CNT_W'(MAX_TRANS)) ? ones_cnt : CNT_W'(LABEL_MIXED);
        code_d = s2_offset + CODE_W'(label);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s2_valid;
            out_code  <= s2_valid ? code_d : '0;
        end
    end

endmodule

// File: rtl/glbp_code_unit.sv
module glbp_code_unit #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned LUMA_BINS = 4,
    parameter int unsigned CODE_W    = $clog2(LUMA_BINS * glbp_pkg::CODE_SPACING)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic                                smooth_en,
    input  logic [glbp_pkg::WIN_TAPS*PIX_W-1:0] win,
    output logic                                out_valid,
    output logic [CODE_W-1:0]                   out_code
);
    import glbp_pkg::*;

    logic                       s1_valid;
    logic [PIX_W-1:0]           s1_centre;
    logic [RING_LEN*PIX_W-1:0]  s1_ring;
    logic                       s2_valid;
    logic [RING_LEN-1:0]        s2_signs;
    logic [CODE_W-1:0]          s2_offset;

    glbp_smooth_stage #(.PIX_W(PIX_W)) u_smooth (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .smooth_en (smooth_en),
        .win       (win),
        .s1_valid  (s1_valid),
        .s1_centre (s1_centre),
        .s1_ring   (s1_ring)
    );

    glbp_sign_stage #(.PIX_W(PIX_W), .LUMA_BINS(LUMA_BINS), .CODE_W(CODE_W)) u_sign (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_centre (s1_centre),
        .s1_ring   (s1_ring),
        .s2_valid  (s2_valid),
        .s2_signs  (s2_signs),
        .s2_offset (s2_offset)
    );

    glbp_label_stage #(.CODE_W(CODE_W)) u_label (
        .clk       (clk),
        .rst_n     (rst_n),
        .s2_valid  (s2_valid),
        .s2_signs  (s2_signs),
        .s2_offset (s2_offset),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

endmodule

// File: rtl/glbp_code_unit_chk.sv
module glbp_code_unit_chk #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned LUMA_BINS = 4,
    parameter int unsigned CODE_W    = 6
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                in_valid,
    input logic                                smooth_en,
    input logic [glbp_pkg::WIN_TAPS*PIX_W-1:0] win,
    input logic                                out_valid,
    input logic [CODE_W-1:0]                   out_code
);
    import glbp_pkg::*;

    localparam int unsigned BIN_W    = (1 << PIX_W) / LUMA_BINS;
    localparam int unsigned MAX_CODE = LUMA_BINS * CODE_SPACING - 1;

    logic [1:0]       since_rst;
    logic             flat_win;
    logic [PIX_W-1:0] centre_now;
    logic [CODE_W-1:0] flat_expect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign centre_now = win[CENTRE_TAP*PIX_W +: PIX_W];

    always_comb begin
        flat_win = 1'b1;
        for (int k = 0; k < WIN_TAPS; k++)
            if (win[k*PIX_W +: PIX_W] != centre_now) flat_win = 1'b0;
        flat_expect = CODE_W'((int'(centre_now) / BIN_W) * CODE_SPACING + RING_LEN);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code <= CODE_W'(MAX_CODE))); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_code == '0)); // R9

    AST_FLAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(in_valid, 3) && !$past(smooth_en, 3) && $past(flat_win, 3))
        |-> (out_code == $past(flat_expect, 3))); // R3

endmodule

bind glbp_code_unit glbp_code_unit_chk #(
    .PIX_W(PIX_W), .LUMA_BINS(LUMA_BINS), .CODE_W(CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .smooth_en (smooth_en),
    .win       (win),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/tb_glbp_code_unit.sv
`timescale 1ns/1ps
module tb_glbp_code_unit;

    typedef struct {
        int    due;
        int    code;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        smooth_en = 1'b0;
    logic [71:0] win = '0;
    logic        out_valid;
    logic [5:0]  out_code;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    glbp_code_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .smooth_en(smooth_en),
        .win(win), .out_valid(out_valid), .out_code(out_code)
    );

    int ring_order[8] = '{0, 1, 2, 5, 8, 7, 6, 3};

    function automatic int tap(logic [71:0] w, int k);
        return int'(w[k*8 +: 8]);
    endfunction

    // Reference built from the requirements alone.
    function automatic int model(logic [71:0] w, bit sm);
        int c;
        int b[8];
        int u;
        int ones;
        int lbl;
        c = tap(w, 4);
        if (sm) c = (4*c + tap(w,1) + tap(w,7) + tap(w,3) + tap(w,5)) / 8;
        ones = 0;
        u = 0;
        for (int p = 0; p < 8; p++) begin
            b[p] = (tap(w, ring_order[p]) >= c) ? 1 : 0;
            ones += b[p];
        end
        for (int p = 0; p < 8; p++) if (b[p] != b[(p+1)%8]) u++;
        lbl = (u <= 2) ? ones : 9;
        return (c / 64) * 10 + lbl;
    endfunction

    function automatic logic [71:0] mk(int c, int r0, int r1, int r2, int r3,
                                       int r4, int r5, int r6, int r7);
        logic [71:0] w;
        int r[8];
        r = '{r0, r1, r2, r3, r4, r5, r6, r7};
        w = '0;
        w[4*8 +: 8] = 8'(c);
        for (int p = 0; p < 8; p++) w[ring_order[p]*8 +: 8] = 8'(r[p]);
        return w;
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: presents one beat and pushes its expected code.
    task automatic drive(logic [71:0] w, bit sm, int fixed_exp, string req);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        smooth_en = sm;
        win       = w;
        e.due  = cyc + 3;
        e.code = (fixed_exp >= 0) ? fixed_exp : model(w, sm);
        e.req  = req;
        if (fixed_exp >= 0 && fixed_exp != model(w, sm))
            $display("bench model disagrees with directed value for %s", req);
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            smooth_en = 1'b0;
            win       = '0;
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", 1, 0, "unexpected out_valid");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.due == cyc, "R2", cyc, e.due, "result cycle");
                    check(int'(out_code) == e.code, e.req, int'(out_code), e.code, "code");
                    check(int'(out_code) <= 39, "R7", int'(out_code), 39, "code range");
                end
            end else begin
                if (sb.size() != 0 && sb[0].due <= cyc)
                    check(1'b0, "R2", 0, 1, "missing out_valid");
                check(out_code == 6'd0, "R9", int'(out_code), 0, "idle code");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hang expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, "valid in reset");
        check(out_code == 6'd0, "R1", int'(out_code), 0, "code in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, "valid after reset");

        // R3 R4 R6: flat window, every neighbour equal to centre -> 8 + 10
        drive(mk(100, 100,100,100,100,100,100,100,100), 1'b0, 18, "R3");
        // R4 R6: all neighbours below bright centre -> 0 + 30
        drive(mk(200, 10,10,10,10,10,10,10,10), 1'b0, 30, "R4");
        // R5: ones at ring 7 and ring 0 join across the wrap -> label 2
        drive(mk(50, 90,10,10,10,10,10,10,90), 1'b0, 2, "R5");
        // R5: alternating ring -> catch-all 9, centre 130 -> 29
        drive(mk(130, 200,0,200,0,200,0,200,0), 1'b0, 29, "R5");
        // R5: two separated ones -> 4 changes -> 9
        drive(mk(20, 99,0,99,0,0,0,0,0), 1'b0, 9, "R5");
        // R6: bin thresholds with neighbours all 0 (label 0)
        drive(mk(63, 0,0,0,0,0,0,0,0), 1'b0, 0, "R6");
        drive(mk(64, 0,0,0,0,0,0,0,0), 1'b0, 10, "R6");
        drive(mk(127, 0,0,0,0,0,0,0,0), 1'b0, 10, "R6");
        drive(mk(128, 0,0,0,0,0,0,0,0), 1'b0, 20, "R6");
        drive(mk(191, 0,0,0,0,0,0,0,0), 1'b0, 20, "R6");
        drive(mk(192, 0,0,0,0,0,0,0,0), 1'b0, 30, "R6");
        // R7: largest code, bright centre with mixed ring -> 39
        drive(mk(255, 255,0,255,0,255,0,255,0), 1'b0, 39, "R7");
        // R8: smoothing moves centre 100 -> 60 (bin 1 -> bin 0)
        drive(mk(100, 0,20,0,20,0,20,0,20), 1'b1, 0, "R8");
        drive(mk(100, 0,20,0,20,0,20,0,20), 1'b0, 10, "R8");
        // R8: centre 60 with edges 200 -> 130, edges now above -> alternating
        drive(mk(60, 0,200,0,200,0,200,0,200), 1'b1, 29, "R8");
        // R8: full-scale sum stays in range -> 255, all equal -> 38
        drive(mk(255, 255,255,255,255,255,255,255,255), 1'b1, 38, "R8");
        idle(6);

        // R2: random beats with gaps, mixed smoothing
        for (int i = 0; i < 400; i++) begin
            logic [71:0] w;
            int c;
            c = $urandom_range(0, 255);
            w = '0;
            for (int k = 0; k < 9; k++) begin
                int r;
                r = $urandom_range(0, 3);
                w[k*8 +: 8] = (r == 0) ? 8'(c) : 8'($urandom_range(0, 255));
            end
            w[4*8 +: 8] = 8'(c);
            drive(w, 1'($urandom_range(0, 1)), -1, "R2");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(6);
        check(sb.size() == 0, "R2", sb.size(), 0, "scoreboard drained");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule